// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block gives two ports, each on its own clock, a way to pass single words to each other without a FIFO in the path. Port A writes into mailbox 1 and reads from mailbox 2. Port B writes into mailbox 2 and reads from mailbox 1. On each port, a mailbox-select input decides whether a transfer goes to a mailbox or to the FIFO path. When a read has mailbox-select low, the port's registered output takes a FIFO word supplied from outside the block.

Each mailbox has a flag, shown once in each clock domain. HIGH means the mailbox is empty. LOW means it holds a word that has not yet been read. The writing side drives the flag low and the reading side releases it. Each side owns its own toggle register. Write and acknowledge events cross between the domains through two-flop toggle synchronizers. The stored word is held still while the flag is low, so the reader takes it directly with no extra synchronization. Each mailbox has its own synchronous active-high reset. That reset is applied in both clock domains and must be held for at least four edges of each clock.

Top module: `mbox_pair`

## Requirements
- R1: A port A write (wr=1) with mailbox-select HIGH, issued while mailbox 1 is empty, stores the word. A later port B read with mailbox-select HIGH returns that word on `b_dout` after the read edge.
- R2: A port B write with mailbox-select HIGH, issued while mailbox 2 is empty, stores the word. A later port A read with mailbox-select HIGH returns that word on `a_dout`.
- R3: A port transfers only at a rising edge where its `cs_n` is LOW and its `en` is HIGH. At any other edge, writes store nothing and reads leave the output register unchanged.
- R4: A read with mailbox-select LOW loads that port's FIFO input word (`a_fifo_q` or `b_fifo_q`) into its output register.
- R5: The writer-side flag (`mb1_flag_a` or `mb2_flag_b`) goes LOW right after the writing edge that stores a word.
- R6: A write to a mailbox whose writer-side flag is LOW is ignored, and the stored word stays unchanged.
- R7: The reader-side flag goes LOW within three reader clock edges after the write. A mailbox read while the reader-side flag is LOW sets it HIGH on that edge. The writer-side flag returns HIGH within three writer clock edges after that read.
- R8: A mailbox read while the reader-side flag is HIGH leaves both flags of that mailbox HIGH, and the next write to it is accepted.
- R9: While `rst_m1` is held, both flags of mailbox 1 go HIGH and `b_dout` clears to zero. Mailbox 2 and `a_dout` are not affected. `rst_m2` acts the same way on mailbox 2 and `a_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_m1 | input | 1 | Mailbox 1 reset, synchronous in both domains, active high |
| rst_m2 | input | 1 | Mailbox 2 reset, synchronous in both domains, active high |
| a_cs_n | input | 1 | Port A select, active low |
| a_en | input | 1 | Port A transfer enable |
| a_wr | input | 1 | Port A direction: 1 = write, 0 = read |
| a_sel | input | 1 | Port A mailbox-select |
| a_din | input | DATA_W | Port A write data |
| a_fifo_q | input | DATA_W | FIFO word returned by port A reads with select low |
| a_dout | output | DATA_W | Port A read output register |
| mb1_flag_a | output | 1 | Mailbox 1 flag, port A domain (LOW = unread word) |
| mb2_flag_a | output | 1 | Mailbox 2 flag, port A domain |
| b_cs_n | input | 1 | Port B select, active low |
| b_en | input | 1 | Port B transfer enable |
| b_wr | input | 1 | Port B direction: 1 = write, 0 = read |
| b_sel | input | 1 | Port B mailbox-select |
| b_din | input | DATA_W | Port B write data |
| b_fifo_q | input | DATA_W | FIFO word returned by port B reads with select low |
| b_dout | output | DATA_W | Port B read output register |
| mb1_flag_b | output | 1 | Mailbox 1 flag, port B domain |
| mb2_flag_b | output | 1 | Mailbox 2 flag, port B domain |

## Verification
The two clocks run at unrelated periods, and each mailbox completes full write, cross, read and release cycles in both directions. A second write issued before the first is collected checks the lockout: a correct design returns the first word, and a design that overwrites returns the second. Reads with select low that fall between mailbox reads check the output mux. Deselected and disabled strobes, an early read of an empty mailbox, and a reset of one mailbox while both hold words each check that state changes only where it should.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;

    // Per-port strobe bundle sampled at the port's rising edge
    typedef struct packed {
        logic cs_n;
        logic en;
        logic wr;
        logic sel;
    } port_req_t;

    // Source routed into a port's read register
    typedef enum logic {
        SRC_FIFO = 1'b0,
        SRC_MAIL = 1'b1
    } rd_src_e;

    localparam int MIN_SYNC = 2;

    function automatic logic port_active(input port_req_t r);
        return (!r.cs_n) && r.en;
    endfunction

    function automatic logic mail_write(input port_req_t r);
        return port_active(r) && r.wr && r.sel;
    endfunction

    function automatic logic mail_read(input port_req_t r);
        return port_active(r) && !r.wr && r.sel;
    endfunction

    function automatic logic any_read(input port_req_t r);
        return port_active(r) && !r.wr;
    endfunction

endpackage

// File: rtl/mbox_tsync.sv
`timescale 1ns/1ps
module mbox_tsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic tgl_out
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= tgl_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign tgl_out = chain[STAGES-1];
endmodule

// File: rtl/mbox_chan.sv
`timescale 1ns/1ps
module mbox_chan #(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              put,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic [DATA_W-1:0] mail_q,
    output logic              free_w,
    output logic              empty_r
);
    // Writer domain
    logic              put_tgl;
    logic              ack_seen;
    logic [DATA_W-1:0] data_q;

    // Reader domain
    logic              ack_tgl;
    logic              put_seen;

    assign free_w  = (put_tgl == ack_seen);
    assign empty_r = (put_seen == ack_tgl);
    assign mail_q  = data_q;

    always_ff @(posedge wclk) begin
        if (rst) begin
            put_tgl <= 1'b0;
            data_q  <= '0;
        end else if (put && free_w) begin
            put_tgl <= ~put_tgl;
            data_q  <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rst)                   ack_tgl <= 1'b0;
        else if (take && !empty_r) ack_tgl <= ~ack_tgl;
    end

    mbox_tsync #(.STAGES(SYNC_STAGES)) u_put_sync (
        .clk(rclk), .rst(rst), .tgl_in(put_tgl), .tgl_out(put_seen)
    );

    mbox_tsync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(wclk), .rst(rst), .tgl_in(ack_tgl), .tgl_out(ack_seen)
    );

    // R5: an accepted write locks the mailbox at once
    assert_lock_on_write_R5: assert property (@(posedge wclk) disable iff (rst)
        (put && free_w) |=> !free_w);

    // R6: the stored word cannot move while the mailbox is locked
    assert_hold_while_locked_R6: assert property (@(posedge wclk) disable iff (rst)
        !free_w |=> $stable(data_q));

    // R7: a read of pending mail releases the reader-side flag
    assert_release_on_read_R7: assert property (@(posedge rclk) disable iff (rst)
        (take && !empty_r) |=> empty_r);

    // R8: no acknowledge is sent for an empty mailbox
    assert_no_ack_when_empty_R8: assert property (@(posedge rclk) disable iff (rst)
        empty_r |=> $stable(ack_tgl));

    // R9: reset leaves both views empty
    assert_reset_free_w_R9: assert property (@(posedge wclk) rst |=> free_w);
    assert_reset_empty_r_R9: assert property (@(posedge rclk) rst |=> empty_r);
endmodule

// File: rtl/mbox_rdport.sv
`timescale 1ns/1ps
module mbox_rdport
    import mbox_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              sel,
    input  logic [DATA_W-1:0] mail_q,
    input  logic [DATA_W-1:0] fifo_q,
    output logic [DATA_W-1:0] dout
);
    rd_src_e           src;
    logic [DATA_W-1:0] pick;

    assign src = sel ? SRC_MAIL : SRC_FIFO;

    always_comb begin
        unique case (src)
            SRC_MAIL: pick = mail_q;
            default:  pick = fifo_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       dout <= '0;
        else if (fire) dout <= pick;
    end

    // R4: a select-low read captures the FIFO word presented at the edge
    assert_fifo_path_R4: assert property (@(posedge clk) disable iff (rst)
        (fire && !sel) |=> (dout == $past(fifo_q)));

    // R3: without a qualified read the output register holds
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(dout));

    // R9: reset clears the output register
    assert_reset_clear_R9: assert property (@(posedge clk) rst |=> (dout == '0));
endmodule

// File: rtl/mbox_pair.sv
`timescale 1ns/1ps
module mbox_pair
    import mbox_pkg::*;
#(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_m1,
    input  logic              rst_m2,
    input  logic              a_cs_n,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_sel,
    input  logic [DATA_W-1:0] a_din,
    input  logic [DATA_W-1:0] a_fifo_q,
    output logic [DATA_W-1:0] a_dout,
    output logic              mb1_flag_a,
    output logic              mb2_flag_a,
    input  logic              b_cs_n,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic              b_sel,
    input  logic [DATA_W-1:0] b_din,
    input  logic [DATA_W-1:0] b_fifo_q,
    output logic [DATA_W-1:0] b_dout,
    output logic              mb1_flag_b,
    output logic              mb2_flag_b
);
    localparam int SYNC_N = (SYNC_STAGES < MIN_SYNC) ? MIN_SYNC : SYNC_STAGES;

    port_req_t         req_a, req_b;
    logic [DATA_W-1:0] m1_q, m2_q;

    assign req_a = '{cs_n: a_cs_n, en: a_en, wr: a_wr, sel: a_sel};
    assign req_b = '{cs_n: b_cs_n, en: b_en, wr: b_wr, sel: b_sel};

    // Mailbox 1: written by port A, read by port B
    mbox_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_N)) u_mb1 (
        .wclk(clk_a), .rclk(clk_b), .rst(rst_m1),
        .put(mail_write(req_a)), .wdata(a_din),
        .take(mail_read(req_b)),
        .mail_q(m1_q), .free_w(mb1_flag_a), .empty_r(mb1_flag_b)
    );

    // Mailbox 2: written by port B, read by port A
    mbox_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_N)) u_mb2 (
        .wclk(clk_b), .rclk(clk_a), .rst(rst_m2),
        .put(mail_write(req_b)), .wdata(b_din),
        .take(mail_read(req_a)),
        .mail_q(m2_q), .free_w(mb2_flag_b), .empty_r(mb2_flag_a)
    );

    mbox_rdport #(.DATA_W(DATA_W)) u_rd_a (
        .clk(clk_a), .rst(rst_m2), .fire(any_read(req_a)), .sel(a_sel),
        .mail_q(m2_q), .fifo_q(a_fifo_q), .dout(a_dout)
    );

    mbox_rdport #(.DATA_W(DATA_W)) u_rd_b (
        .clk(clk_b), .rst(rst_m1), .fire(any_read(req_b)), .sel(b_sel),
        .mail_q(m1_q), .fifo_q(b_fifo_q), .dout(b_dout)
    );

    // R3: a deselected port A strobe cannot lock mailbox 1
    assert_deselect_no_lock_R3: assert property (@(posedge clk_a) disable iff (rst_m1)
        (mb1_flag_a && !port_active(req_a)) |=> mb1_flag_a);
endmodule

// File: tb/mbox_pair_bench.sv
`timescale 1ns/1ps
module mbox_pair_bench;
    localparam int W = 36;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_m1 = 1'b1, rst_m2 = 1'b1;
    logic a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0, a_sel = 1'b0;
    logic b_cs_n = 1'b1, b_en = 1'b0, b_wr = 1'b0, b_sel = 1'b0;
    logic [W-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
    logic [W-1:0] a_dout, b_dout;
    logic mb1_flag_a, mb2_flag_a, mb1_flag_b, mb2_flag_b;

    int checks = 0, errors = 0;
    logic [W-1:0] exp_m1 = '0, exp_m2 = '0;
    logic [W-1:0] q_a[$], q_b[$];
    string        t_a[$], t_b[$];

    always #5 clk_a = ~clk_a;
    initial begin
        #2;
        forever #7 clk_b = ~clk_b;
    end

    mbox_pair #(.DATA_W(W)) u_mbox_pair (.*);

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic a_op(input logic wr, input logic sel, input logic [W-1:0] din,
                        input logic [W-1:0] fifo, input string tag,
                        input logic cs_n = 1'b0, input logic en = 1'b1);
        @(negedge clk_a);
        a_cs_n = cs_n; a_en = en; a_wr = wr; a_sel = sel; a_din = din; a_fifo_q = fifo;
        if (!wr && !cs_n && en) begin
            q_a.push_back(sel ? exp_m2 : fifo);
            t_a.push_back(tag);
        end
        @(negedge clk_a);
        a_cs_n = 1'b1; a_en = 1'b0;
    endtask

    task automatic b_op(input logic wr, input logic sel, input logic [W-1:0] din,
                        input logic [W-1:0] fifo, input string tag,
                        input logic cs_n = 1'b0, input logic en = 1'b1);
        @(negedge clk_b);
        b_cs_n = cs_n; b_en = en; b_wr = wr; b_sel = sel; b_din = din; b_fifo_q = fifo;
        if (!wr && !cs_n && en) begin
            q_b.push_back(sel ? exp_m1 : fifo);
            t_b.push_back(tag);
        end
        @(negedge clk_b);
        b_cs_n = 1'b1; b_en = 1'b0;
    endtask

    // Monitors: pop the scoreboard when a qualified read lands
    always @(posedge clk_a) begin
        if (!rst_m2 && !a_cs_n && a_en && !a_wr) begin
            @(negedge clk_a);
            if (q_a.size() == 0) check("port A unexpected read", a_dout, 'x);
            else check(t_a.pop_front(), a_dout, q_a.pop_front());
        end
    end

    always @(posedge clk_b) begin
        if (!rst_m1 && !b_cs_n && b_en && !b_wr) begin
            @(negedge clk_b);
            if (q_b.size() == 0) check("port B unexpected read", b_dout, 'x);
            else check(t_b.pop_front(), b_dout, q_b.pop_front());
        end
    end

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    logic [W-1:0] hold;

    initial begin
        repeat (8) @(negedge clk_a);
        rst_m1 = 1'b0; rst_m2 = 1'b0;
        @(negedge clk_a);
        // R9 reset state
        check("R9 mb1_flag_a after reset", W'(mb1_flag_a), W'(1));
        check("R9 mb2_flag_a after reset", W'(mb2_flag_a), W'(1));
        check("R9 mb1_flag_b after reset", W'(mb1_flag_b), W'(1));
        check("R9 mb2_flag_b after reset", W'(mb2_flag_b), W'(1));
        check("R9 a_dout after reset", a_dout, '0);
        check("R9 b_dout after reset", b_dout, '0);

        // R4 FIFO path on both ports
        a_op(1'b0, 1'b0, '0, 36'h0_1234_5678, "R4 port A fifo read");
        b_op(1'b0, 1'b0, '0, 36'hA_BCDE_F012, "R4 port B fifo read");

        // R1 / R5 / R7: mailbox 1 full cycle
        a_op(1'b1, 1'b1, 36'h1_1111_0001, '0, "");
        exp_m1 = 36'h1_1111_0001;
        check("R5 mb1_flag_a low after write", W'(mb1_flag_a), W'(0));
        repeat (4) @(negedge clk_b);
        check("R7 mb1_flag_b low after crossing", W'(mb1_flag_b), W'(0));
        b_op(1'b0, 1'b1, '0, 36'hF_FFFF_FFFF, "R1 port B mailbox read");
        check("R7 mb1_flag_b high after read", W'(mb1_flag_b), W'(1));
        repeat (4) @(negedge clk_a);
        check("R7 mb1_flag_a released", W'(mb1_flag_a), W'(1));

        // R6: second write while locked is dropped
        a_op(1'b1, 1'b1, 36'h2_2222_0002, '0, "");
        exp_m1 = 36'h2_2222_0002;
        a_op(1'b1, 1'b1, 36'h3_3333_0003, '0, "");
        check("R6 mb1_flag_a still low", W'(mb1_flag_a), W'(0));
        repeat (4) @(negedge clk_b);
        b_op(1'b0, 1'b1, '0, '0, "R6 locked write ignored");
        repeat (4) @(negedge clk_a);

        // R3: deselected / disabled strobes
        a_op(1'b1, 1'b1, 36'h4_4444_0004, '0, "", 1'b1, 1'b1);
        check("R3 cs_n high write no lock", W'(mb1_flag_a), W'(1));
        a_op(1'b1, 1'b1, 36'h5_5555_0005, '0, "", 1'b0, 1'b0);
        check("R3 en low write no lock", W'(mb1_flag_a), W'(1));
        hold = b_dout;
        b_op(1'b0, 1'b0, '0, 36'h7_7777_7777, "", 1'b1, 1'b1);
        check("R3 cs_n high read keeps b_dout", b_dout, hold);

        // R8: mailbox read while empty returns held word, flags stay high
        b_op(1'b0, 1'b1, '0, '0, "R8 empty mailbox read");
        check("R8 mb1_flag_b stays high", W'(mb1_flag_b), W'(1));
        repeat (4) @(negedge clk_a);
        check("R8 mb1_flag_a stays high", W'(mb1_flag_a), W'(1));
        a_op(1'b1, 1'b1, 36'h6_6666_0006, '0, "");
        exp_m1 = 36'h6_6666_0006;
        check("R8 next write accepted", W'(mb1_flag_a), W'(0));
        repeat (4) @(negedge clk_b);
        b_op(1'b0, 1'b1, '0, '0, "R8 accepted word read back");
        repeat (4) @(negedge clk_a);

        // R2: mailbox 2 full cycle, with a FIFO read interleaved on port A
        b_op(1'b1, 1'b1, 36'h8_8888_0008, '0, "");
        exp_m2 = 36'h8_8888_0008;
        check("R5 mb2_flag_b low after write", W'(mb2_flag_b), W'(0));
        a_op(1'b0, 1'b0, '0, 36'h9_0000_0009, "R4 fifo read between mail");
        repeat (4) @(negedge clk_a);
        check("R7 mb2_flag_a low after crossing", W'(mb2_flag_a), W'(0));
        a_op(1'b0, 1'b1, '0, '0, "R2 port A mailbox read");
        check("R7 mb2_flag_a high after read", W'(mb2_flag_a), W'(1));
        repeat (4) @(negedge clk_b);
        check("R7 mb2_flag_b released", W'(mb2_flag_b), W'(1));

        // R9: reset of mailbox 1 only, both mailboxes pending
        a_op(1'b1, 1'b1, 36'hA_0000_000A, '0, "");
        b_op(1'b1, 1'b1, 36'hB_0000_000B, '0, "");
        exp_m2 = 36'hB_0000_000B;
        repeat (4) @(negedge clk_a);
        a_op(1'b0, 1'b0, '0, 36'hC_0000_000C, "R4 fifo read before reset");
        @(negedge clk_a);
        rst_m1 = 1'b1;
        repeat (8) @(negedge clk_a);
        rst_m1 = 1'b0;
        exp_m1 = '0;
        @(negedge clk_a);
        check("R9 mb1_flag_a after own reset", W'(mb1_flag_a), W'(1));
        check("R9 mb1_flag_b after own reset", W'(mb1_flag_b), W'(1));
        check("R9 b_dout cleared", b_dout, '0);
        check("R9 mb2_flag_a untouched", W'(mb2_flag_a), W'(0));
        check("R9 a_dout untouched", a_dout, 36'hC_0000_000C);
        a_op(1'b0, 1'b1, '0, '0, "R9 mailbox 2 word survives");

        repeat (6) @(negedge clk_b);
        check("R9 scoreboard drained", W'(q_a.size() + q_b.size()), '0);
        finish_run();
    end
endmodule